// File: doc/BRIEF.md
# Byte-Lane Memory Subordinate

This block is a subordinate on an AHB-Lite bus with a 32-bit data path, backed by a small word-organised register-file memory. Each transfer has two phases. In the address phase the block samples the select, transfer type, direction, size and address. In the following data phase it either writes the byte lanes picked by the captured size and low address bits, or returns the addressed word on the read bus. Bursts need no special handling: every beat is taken as its own transfer.

The block never adds wait states and never signals an error. Its ready output is held high and its response is always OKAY, so it applies no back-pressure. A manager may issue transfers back to back: the address phase of one transfer overlaps the data phase of the one before. The shared bus-ready input only gates when a new address phase is taken.

Top module: `lanemem_sub`

## Requirements
- R1: `readyout_o` is 1 and `resp_o` is 0 (OKAY) in every cycle, during reset as well.
- R2: A write of size code 3'b010 (word) replaces all four bytes of the addressed word.
- R3: A write of size code 3'b001 (halfword) writes bytes 0–1 (bits 15:0) when address bit 1 is 0, and bytes 2–3 (bits 31:16) when it is 1. Address bit 0 is ignored. The other two bytes keep their values.
- R4: A write of size code 3'b000 (byte) writes only byte lane `addr_i[1:0]` (bits 8*lane+7 : 8*lane). The other three bytes keep their values.
- R5: An address phase is taken only when the transfer type is NONSEQ (2'b10) or SEQ (2'b11). With IDLE (2'b00) or BUSY (2'b01), the following data phase writes nothing.
- R6: An address phase with `sel_i` low writes nothing in the following data phase.
- R7: An address phase presented while `ready_i` is low is not taken, and the following data phase writes nothing.
- R8: A write with a size code from 3'b011 to 3'b111 (wider than the 32-bit bus) changes no byte.
- R9: A read returns the full 32-bit word at index `addr_i[9:2]` during its data phase. A read issued in the address phase that overlaps a write's data phase to the same word returns the newly written data.
- R10: Only address bits [9:2] select a word with the default depth of 256. Addresses that differ only in bits above bit 9 reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Active-low reset; clears the captured transfer |
| sel_i | input | 1 | Subordinate select |
| addr_i | input | 32 | Byte address (address phase) |
| trans_i | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| write_i | input | 1 | 1 = write, 0 = read (address phase) |
| size_i | input | 3 | Beat size code; 2^code bytes |
| ready_i | input | 1 | Bus-wide ready; an address phase is taken only when it is high |
| wdata_i | input | 32 | Write data (data phase) |
| rdata_o | output | 32 | Read data (data phase) |
| readyout_o | output | 1 | Always 1 |
| resp_o | output | 1 | Always 0 (OKAY) |

## Verification
The write of one transfer's data phase and the capture of the next transfer's address phase fall in the same cycle. The sharpest case is a write followed at once by a read of the same word. The bench provokes this by presenting the read address in the same cycle as the write data. It judges the result by requiring the read's data phase to carry the new word. A near-exhaustive sweep over every size code and every low-address pair then reads each word back and compares it with a merge of old and new bytes worked out arithmetically.

// File: rtl/lanemem_pkg.sv
package lanemem_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  function automatic logic beat_active(input logic [1:0] t);
    return (t == TR_NONSEQ) || (t == TR_SEQ);
  endfunction
endpackage

// File: rtl/lanemem_capture.sv
module lanemem_capture #(
  parameter int LB = 2,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          ready_i,
  input  logic [1:0]    trans_i,
  input  logic          write_i,
  input  logic [2:0]    size_i,
  input  logic [LB-1:0] low_i,
  input  logic [IW-1:0] idx_i,
  output logic          dph_valid_o,
  output logic          dph_write_o,
  output logic [2:0]    dph_size_o,
  output logic [LB-1:0] dph_low_o,
  output logic [IW-1:0] dph_idx_o
);
  import lanemem_pkg::*;

  logic take;
  assign take = sel_i && beat_active(trans_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_valid_o <= 1'b0;
      dph_write_o <= 1'b0;
      dph_size_o  <= '0;
      dph_low_o   <= '0;
      dph_idx_o   <= '0;
    end else if (ready_i) begin
      dph_valid_o <= take;
      dph_write_o <= write_i;
      dph_size_o  <= size_i;
      dph_low_o   <= low_i;
      dph_idx_o   <= idx_i;
    end
  end

  // R5/R6: an inactive or unselected address phase leaves no pending beat
  a_r5_idle_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && (!sel_i || trans_i == TR_IDLE || trans_i == TR_BUSY)) |=> !dph_valid_o);

  // R7: a stalled bus freezes the captured transfer
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> ($stable(dph_valid_o) && $stable(dph_idx_o) && $stable(dph_low_o)));
endmodule

// File: rtl/lanemem_lanedec.sv
module lanemem_lanedec #(
  parameter int LANES = 4,
  parameter int LB    = 2
) (
  input  logic [2:0]       size_i,
  input  logic [LB-1:0]    low_i,
  output logic [LANES-1:0] lanes_o
);
  localparam int MAXSZ = $clog2(LANES);

  logic fits;
  assign fits = (int'(size_i) <= MAXSZ);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LB-1:0] IDX = LB'(g);
    assign lanes_o[g] = fits && ((IDX >> size_i) == (low_i >> size_i));
  end

  always_comb begin
    if (size_i == 3'd0)
      a_r4_one_lane: assert ($countones(lanes_o) == 1);
    if (size_i == 3'd1)
      a_r3_two_lanes: assert ($countones(lanes_o) == 2);
  end
endmodule

// File: rtl/lanemem_store.sv
module lanemem_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int LANES  = DATA_W / 8,
  parameter int IW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar l = 0; l < LANES; l++) begin : g_byte
    always_ff @(posedge clk) begin
      if (we_i[l]) mem[idx_i][l*8 +: 8] <= wdata_i[l*8 +: 8];
    end
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/lanemem_sub.sv
module lanemem_sub #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              readyout_o,
  output logic              resp_o
);
  localparam int LANES = DATA_W / 8;
  localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int IW    = $clog2(DEPTH);

  logic             dph_valid, dph_write;
  logic [2:0]       dph_size;
  logic [LB-1:0]    dph_low;
  logic [IW-1:0]    dph_idx;
  logic [LANES-1:0] lanes, byte_we;
  logic             unused_hi_bits;

  assign unused_hi_bits = ^addr_i[ADDR_W-1:IW+LB];

  lanemem_capture #(.LB(LB), .IW(IW)) cap_i (
    .clk(bus_clk), .rst_n(bus_rst_n), .sel_i(sel_i), .ready_i(ready_i),
    .trans_i(trans_i), .write_i(write_i), .size_i(size_i),
    .low_i(addr_i[LB-1:0]), .idx_i(addr_i[IW+LB-1:LB]),
    .dph_valid_o(dph_valid), .dph_write_o(dph_write), .dph_size_o(dph_size),
    .dph_low_o(dph_low), .dph_idx_o(dph_idx)
  );

  lanemem_lanedec #(.LANES(LANES), .LB(LB)) dec_i (
    .size_i(dph_size), .low_i(dph_low), .lanes_o(lanes)
  );

  assign byte_we = (dph_valid && dph_write && ready_i) ? lanes : '0;

  lanemem_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(LANES), .IW(IW)) mem_i (
    .clk(bus_clk), .we_i(byte_we), .idx_i(dph_idx),
    .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  assign readyout_o = 1'b1;
  assign resp_o     = 1'b0;

  a_r1_ready_okay: assert property (@(posedge bus_clk)
    readyout_o && !resp_o);

  a_r6_no_write_without_beat: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !dph_valid |-> (byte_we == '0));

  a_r2_word_all_lanes: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (dph_valid && dph_write && ready_i && dph_size == 3'd2 && LANES == 4) |-> (&byte_we));
endmodule

// File: tb/lanemem_sub_tb_top.sv
`timescale 1ns/1ps
module lanemem_sub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel;
  logic [31:0] addr;
  logic [1:0]  trans;
  logic        wr;
  logic [2:0]  size;
  logic        rdy;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        readyout, resp;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  lanemem_sub dut_i (
    .bus_clk(clk), .bus_rst_n(rst_n), .sel_i(sel), .addr_i(addr),
    .trans_i(trans), .write_i(wr), .size_i(size), .ready_i(rdy),
    .wdata_i(wdata), .rdata_o(rdata), .readyout_o(readyout), .resp_o(resp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_aph();
    sel = 1'b0; trans = 2'b00; wr = 1'b0; size = 3'd0;
  endtask

  task automatic xfer_wr(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d,
                         input logic [1:0] t, input logic s, input logic r);
    @(negedge clk);
    sel = s; trans = t; wr = 1'b1; size = sz; addr = a; rdy = r;
    @(negedge clk);
    idle_aph(); rdy = 1'b1; wdata = d;
  endtask

  task automatic xfer_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; trans = 2'b10; wr = 1'b0; size = 3'd2; addr = a; rdy = 1'b1;
    @(negedge clk);
    idle_aph();
    d = rdata;
  endtask

  function automatic logic [31:0] byte_mask(input logic [2:0] sz, input logic [1:0] lo);
    logic [31:0] m = '0;
    if (sz <= 3'd2) begin
      int nb    = 1 << sz;
      int first = int'(lo) & ~(nb - 1);
      for (int b = first; b < first + nb; b++) m[b*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] got, base, d, m, exp;
    rst_n = 1'b0; idle_aph(); addr = '0; rdy = 1'b1; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'd0, readyout}, 32'd1);
    check("R1 resp in reset", {31'd0, resp}, 32'd0);
    rst_n = 1'b1;

    // R2/R3/R4/R8 sweep: every size code against every low address pair
    for (int sz = 0; sz < 8; sz++) begin
      for (int lo = 0; lo < 4; lo++) begin
        int k = 16 + sz * 4 + lo;
        base = 32'hA5C3_0F00 ^ (k * 32'h0101_0101);
        d    = 32'h1122_3344 ^ (k * 32'h0001_0203);
        xfer_wr(k * 4, 3'd2, base, 2'b10, 1'b1, 1'b1);
        xfer_wr(k * 4 + lo, 3'(sz), d, 2'b11, 1'b1, 1'b1);
        xfer_rd(k * 4, got);
        m   = byte_mask(3'(sz), 2'(lo));
        exp = (base & ~m) | (d & m);
        check(sz == 2 ? "R2 word" : sz == 1 ? "R3 halfword" : sz == 0 ? "R4 byte" : "R8 oversize",
              got, exp);
      end
    end

    // R5: IDLE and BUSY make no write
    xfer_wr(32'h100, 3'd2, 32'h0000_0000, 2'b10, 1'b1, 1'b1);
    xfer_wr(32'h100, 3'd2, 32'hDEAD_BEEF, 2'b00, 1'b1, 1'b1);
    xfer_rd(32'h100, got); check("R5 idle", got, 32'h0);
    xfer_wr(32'h100, 3'd2, 32'hDEAD_BEEF, 2'b01, 1'b1, 1'b1);
    xfer_rd(32'h100, got); check("R5 busy", got, 32'h0);
    // R6: unselected
    xfer_wr(32'h100, 3'd2, 32'hCAFE_F00D, 2'b10, 1'b0, 1'b1);
    xfer_rd(32'h100, got); check("R6 unselected", got, 32'h0);
    // R7: stalled address phase not taken
    xfer_wr(32'h100, 3'd2, 32'h1234_5678, 2'b10, 1'b1, 1'b0);
    xfer_rd(32'h100, got); check("R7 stalled", got, 32'h0);
    check("R1 ready running", {31'd0, readyout}, 32'd1);

    // R9: read address phase overlaps write data phase to the same word
    @(negedge clk);
    sel = 1'b1; trans = 2'b10; wr = 1'b1; size = 3'd2; addr = 32'h1F0;
    @(negedge clk);
    wdata = 32'h5A5A_C3C3; wr = 1'b0;
    @(negedge clk);
    idle_aph();
    check("R9 overlap read", rdata, 32'h5A5A_C3C3);

    // R10: bits above 9 alias
    xfer_wr(32'h0000_0420, 3'd2, 32'h0BAD_CAFE, 2'b10, 1'b1, 1'b1);
    xfer_rd(32'h0000_0020, got); check("R10 alias", got, 32'h0BAD_CAFE);
    xfer_rd(32'h8000_0020, got); check("R10 alias high", got, 32'h0BAD_CAFE);
    check("R1 resp running", {31'd0, resp}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule